// File: doc/BRIEF.md
# Serial Memory Slave Protocol Engine

This block is the two-wire slave front end of a 256-byte byte-addressed store. It oversamples the serial clock and data lines with a fast system clock and recognises START and STOP conditions on them. After a START it takes in an address byte and answers only to a four-bit device prefix plus three strap pins. It then carries out byte and page writes, current-address reads, random reads and sequential reads. It drives the data line only through an open-drain pull-low enable.

Received data bytes leave the block one at a time on a write strobe toward a separate page-buffer block. A commit strobe tells that block when the write transaction has closed. Read data comes from a synchronous memory port that the block addresses with its internal byte pointer. The pointer persists across transactions. While the companion buffer reports an internal programming cycle through the busy input, the engine ignores the bus entirely.

Top module: `serial_mem_slave`

## Requirements
- R1: A START (data falling while clock is high) is the only way to leave idle. Address bits clocked without a START get no acknowledge. A STOP (data rising while clock is high) releases the line and returns to idle. After reset the pull-low enable, write strobe and commit strobe are all 0.
- R2: The address byte is sent MSB first. Its bits [7:4] must equal 4'b1010 and bits [3:1] must equal the strap inputs; bit 0 is 1 for read and 0 for write. A matching byte is acknowledged by pulling data low during the ninth clock. A non-matching byte gets no acknowledge, and no write strobe occurs before the next START or STOP.
- R3: In a write, the first byte after the address loads the 8-bit byte pointer and is acknowledged.
- R4: Each further write byte is acknowledged and produces a one-cycle write strobe carrying the pointer and the byte. The pointer then increments modulo 256.
- R5: A STOP that ends a transaction in which at least one data byte was written produces a one-cycle commit strobe.
- R6: A read with no address phase returns the byte at the pointer, which is the last accessed address plus one. The pointer wraps from 255 to 0.
- R7: A random read (write-mode address, byte address, repeated START, read-mode address) returns the byte at the newly loaded address.
- R8: In a read, a master acknowledge yields the next byte at pointer plus one, wrapping past 255. A master no-acknowledge releases the line until the next START or STOP.
- R9: While busy is 1 the engine does not acknowledge its address, keeps the line released and emits no write strobe.
- R10: The pull-low enable changes only after the clock has fallen, never while the clock is high. Transmitted bytes go out MSB first.
- R11: A START in the middle of a byte aborts that byte and restarts address reception from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| strap | input | 3 | Device select straps compared with address bits [3:1] |
| busy | input | 1 | Internal programming in progress; engine goes deaf |
| wr_stb | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 8 | Byte address for the strobe |
| wr_data | output | 8 | Data byte for the strobe |
| wr_commit | output | 1 | One-cycle strobe on STOP after written data |
| rd_addr | output | 8 | Current byte pointer, address of the memory read port |
| rd_data | input | 8 | Read data, registered one cycle after rd_addr |

## Verification
The assertions take for granted a clean bus: each clock phase lasts many system cycles, data changes only while the clock is low except for START and STOP, and busy only changes while the bus is idle. The stimulus holds each clock phase for tens of cycles and changes data a quarter period after the falling edge. Busy is raised and lowered only between transactions. The bench's memory model answers the read port with one cycle of latency, matching the synchronous port the engine expects.

// File: rtl/sms_pkg.sv
package sms_pkg;

    localparam int BYTE_W   = 8;
    localparam int STRAP_W  = 3;
    localparam int PREFIX_W = 4;
    localparam logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WADDR,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } sms_state_e;

    typedef struct packed {
        logic [PREFIX_W-1:0] prefix;
        logic [STRAP_W-1:0]  sel;
        logic                rnw;
    } sms_addr_t;

    function automatic logic addr_ok(input logic [BYTE_W-1:0] b,
                                     input logic [STRAP_W-1:0] s);
        sms_addr_t a;
        a = sms_addr_t'(b);
        return (a.prefix == DEV_PREFIX) && (a.sel == s);
    endfunction

endpackage

// File: rtl/sms_sync.sv
module sms_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] prev
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end
        assign lvl[g]  = chain[STAGES-1];
        assign prev[g] = last;
    end
endmodule

// File: rtl/sms_shift.sv
module sms_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] value,
    output logic         full
);
    localparam int CW = $clog2(W + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            if (rst) value <= '0;
        end else if (step && !full) begin
            cnt   <= cnt + 1'b1;
            value <= {value[W-2:0], din};
        end
    end

    assign full = (cnt == CW'(W));
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import sms_pkg::*;
#(
    parameter int AW = BYTE_W,
    parameter int DW = BYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic [STRAP_W-1:0] strap,
    input  logic               busy,
    output logic               wr_stb,
    output logic [AW-1:0]      wr_addr,
    output logic [DW-1:0]      wr_data,
    output logic               wr_commit,
    output logic [AW-1:0]      rd_addr,
    input  logic [DW-1:0]      rd_data
);
    localparam int SCL_I = 1;
    localparam int SDA_I = 0;

    logic [1:0] lvl, prev;
    sms_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .raw({scl_in, sda_in}), .lvl(lvl), .prev(prev)
    );

    logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
    assign scl_s    = lvl[SCL_I];
    assign sda_s    = lvl[SDA_I];
    assign scl_rise = scl_s && !prev[SCL_I];
    assign scl_fall = !scl_s && prev[SCL_I];
    assign start_w  = scl_s && prev[SCL_I] && prev[SDA_I] && !sda_s;
    assign stop_w   = scl_s && prev[SCL_I] && !prev[SDA_I] && sda_s;

    sms_state_e      state;
    logic [AW-1:0]   ptr;
    logic [DW-1:0]   tx;
    logic            rnw, wrote, mack;
    logic [DW-1:0]   rx_byte;
    logic            rx_full, ack_phase, shift_phase;

    assign ack_phase   = (state == ST_AACK) || (state == ST_WACK) || (state == ST_RACK);
    assign shift_phase = (state == ST_ADDR) || (state == ST_WADDR) ||
                         (state == ST_WDATA) || (state == ST_RDATA);

    sms_shift #(.W(DW)) u_shift (
        .clk(clk), .rst(rst),
        .clr(start_w || (scl_fall && ack_phase)),
        .step(scl_rise && shift_phase),
        .din(sda_s),
        .value(rx_byte), .full(rx_full)
    );

    always_ff @(posedge clk) begin
        wr_stb    <= 1'b0;
        wr_commit <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
            ptr      <= '0;
            tx       <= '0;
            rnw      <= 1'b0;
            wrote    <= 1'b0;
            mack     <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (busy) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (start_w) begin
            state    <= ST_ADDR;
            sda_pull <= 1'b0;
            wrote    <= 1'b0;
        end else if (stop_w) begin
            state     <= ST_IDLE;
            sda_pull  <= 1'b0;
            wr_commit <= wrote;
            wrote     <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: if (scl_fall && rx_full) begin
                    if (addr_ok(rx_byte, strap)) begin
                        sda_pull <= 1'b1;
                        rnw      <= rx_byte[0];
                        state    <= ST_AACK;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_AACK: if (scl_fall) begin
                    if (rnw) begin
                        tx       <= rd_data;
                        sda_pull <= !rd_data[DW-1];
                        state    <= ST_RDATA;
                    end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_WADDR;
                    end
                end
                ST_WADDR: if (scl_fall && rx_full) begin
                    ptr      <= rx_byte[AW-1:0];
                    sda_pull <= 1'b1;
                    state    <= ST_WACK;
                end
                ST_WDATA: if (scl_fall && rx_full) begin
                    wr_stb   <= 1'b1;
                    wr_addr  <= ptr;
                    wr_data  <= rx_byte;
                    ptr      <= ptr + 1'b1;
                    wrote    <= 1'b1;
                    sda_pull <= 1'b1;
                    state    <= ST_WACK;
                end
                ST_WACK: if (scl_fall) begin
                    sda_pull <= 1'b0;
                    state    <= ST_WDATA;
                end
                ST_RDATA: if (scl_fall) begin
                    if (rx_full) begin
                        sda_pull <= 1'b0;
                        ptr      <= ptr + 1'b1;
                        state    <= ST_RACK;
                    end else begin
                        sda_pull <= !tx[DW-2];
                        tx       <= {tx[DW-2:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack <= !sda_s;
                    if (scl_fall) begin
                        if (mack) begin
                            tx       <= rd_data;
                            sda_pull <= !rd_data[DW-1];
                            state    <= ST_RDATA;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_addr = ptr;

    // R9: busy leaves the line released on the next cycle
    a_r9_busy_release: assert property (@(posedge clk) disable iff (rst)
        busy |=> !sda_pull);

    // R10: the pull enable moves only after a clock fall or a bus condition
    a_r10_pull_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> $past(scl_fall || start_w || stop_w || busy));

    // R4: write strobe lasts one cycle and the pointer has stepped past it
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> rd_addr == wr_addr + 1'b1);

    // R5: commit only arrives with the line released
    a_r5_commit_released: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> !sda_pull);

    // R2: an address acknowledge always follows a matching byte
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_pull) && state == ST_AACK) |-> addr_ok(rx_byte, strap));

endmodule

// File: tb/serial_mem_slave_tb.sv
module serial_mem_slave_tb;
    localparam int Q = 20;
    localparam logic [2:0] STRAP = 3'b101;
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{
        {8'h00, 8'h3C}, {8'h01, 8'hA5}, {8'h7F, 8'h11},
        {8'h80, 8'hEE}, {8'hC3, 8'h5A}, {8'hFF, 8'h96}
    };

    logic clk = 0, rst = 1, busy = 0;
    logic m_scl = 1, m_sda = 1;
    logic sda_pull, wr_stb, wr_commit;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic sda_line;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int n_chk = 0, n_fail = 0, n_wr = 0, n_commit = 0, n_viol = 0;
    logic prev_pull = 0;
    logic [7:0] last_wa, last_wd;

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    serial_mem_slave u_dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .strap(STRAP), .busy(busy),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    initial for (int i = 0; i < 256; i++) begin
        mem[i] = 8'(i) ^ 8'h5A;
        exp_mem[i] = 8'(i) ^ 8'h5A;
    end

    always @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (wr_stb) begin
            mem[wr_addr] <= wr_data;
            n_wr++;
            last_wa = wr_addr;
            last_wd = wr_data;
        end
        if (wr_commit) n_commit++;
        if (!rst && sda_pull !== prev_pull && m_scl) n_viol++;
        prev_pull <= sda_pull;
    end

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tk(input int n); repeat (n) @(negedge clk); endtask

    task automatic send_bit(input logic b);
        m_sda = b; tk(Q); m_scl = 1; tk(2*Q); m_scl = 0; tk(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1; tk(Q); m_scl = 1; tk(Q); b = sda_line; tk(Q); m_scl = 0; tk(Q);
    endtask

    task automatic wb(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic rb(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(!give_ack);
    endtask

    task automatic bus_start;
        m_sda = 1; tk(Q); m_scl = 1; tk(Q); m_sda = 0; tk(Q); m_scl = 0; tk(Q);
    endtask

    task automatic bus_stop;
        m_sda = 0; tk(Q); m_scl = 1; tk(Q); m_sda = 1; tk(2*Q);
    endtask

    function automatic logic [7:0] dev(input logic rnw);
        return {4'b1010, STRAP, rnw};
    endfunction

    task automatic rand_read(input logic [7:0] a, output logic [7:0] d, output logic ok);
        logic k1, k2, k3;
        bus_start; wb(dev(0), k1); wb(a, k2);
        bus_start; wb(dev(1), k3); rb(0, d); bus_stop;
        ok = k1 && k2 && k3;
    endtask

    initial begin : wdog
        repeat (180000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic k1, k2, k3, ok;
        logic [7:0] d;
        int w0, c0;
        tk(5); rst = 0; tk(5);
        // R1: reset state
        chk(!sda_pull && !wr_stb && !wr_commit, "R1 reset outputs", sda_pull, 0);

        // R1: no START, no acknowledge
        m_scl = 0; tk(Q);
        wb(dev(0), k1);
        chk(!k1, "R1 ack without start", k1, 0);
        bus_stop;

        // Vector table: byte write then random read back (R3 R4 R5 R7)
        for (int v = 0; v < NV; v++) begin
            logic [7:0] a, dd;
            a = VEC[v][15:8]; dd = VEC[v][7:0];
            c0 = n_commit;
            bus_start; wb(dev(0), k1); wb(a, k2); wb(dd, k3); bus_stop;
            exp_mem[a] = dd;
            chk(k1 && k2 && k3, "R3 write acks", {k1, k2, k3}, 7);
            chk(last_wa == a && last_wd == dd, "R4 strobe fields", {last_wa, last_wd}, {a, dd});
            chk(n_commit == c0 + 1, "R5 commit count", n_commit, c0 + 1);
            rand_read(a, d, ok);
            chk(ok && d == exp_mem[a], "R7 random read", d, exp_mem[a]);
        end

        // R6: pointer sits at 0 after reading 0xFF
        bus_start; wb(dev(1), k1); rb(0, d); bus_stop;
        chk(k1 && d == exp_mem[0], "R6 current read wrap", d, exp_mem[0]);
        bus_start; wb(dev(1), k1); rb(0, d); bus_stop;
        chk(k1 && d == exp_mem[1], "R6 current read next", d, exp_mem[1]);

        // R8: sequential across the wrap, then NACK releases line
        bus_start; wb(dev(0), k1); wb(8'hFE, k2); bus_start; wb(dev(1), k3);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] ea;
            ea = 8'(8'hFE + i);
            rb(i < 3, d);
            chk(d == exp_mem[ea], "R8 sequential byte", d, exp_mem[ea]);
        end
        rb(0, d);
        chk(d == 8'hFF, "R8 released after nack", d, 8'hFF);
        bus_stop;

        // R4 R5: page write of three bytes
        w0 = n_wr; c0 = n_commit;
        bus_start; wb(dev(0), k1); wb(8'h40, k2);
        for (int i = 0; i < 3; i++) begin
            wb(8'hC0 + 8'(i), k3);
            exp_mem[8'h40 + i] = 8'hC0 + 8'(i);
            chk(k3, "R4 data ack", k3, 1);
        end
        bus_stop;
        chk(n_wr == w0 + 3, "R4 strobe count", n_wr, w0 + 3);
        chk(n_commit == c0 + 1, "R5 page commit", n_commit, c0 + 1);
        rand_read(8'h42, d, ok);
        chk(ok && d == exp_mem[8'h42], "R4 page readback", d, exp_mem[8'h42]);

        // R2: wrong strap and wrong prefix
        w0 = n_wr; c0 = n_commit;
        bus_start; wb({4'b1010, 3'b000, 1'b0}, k1); wb(8'h40, k2); wb(8'h99, k3); bus_stop;
        chk(!k1, "R2 strap mismatch nack", k1, 0);
        bus_start; wb({4'b1011, STRAP, 1'b0}, k1); wb(8'h40, k2); wb(8'h99, k3); bus_stop;
        chk(!k1, "R2 prefix mismatch nack", k1, 0);
        chk(n_wr == w0 && n_commit == c0, "R2 no strobe", n_wr, w0);
        rand_read(8'h40, d, ok);
        chk(d == exp_mem[8'h40], "R2 memory unchanged", d, exp_mem[8'h40]);

        // R9: busy makes the engine deaf
        w0 = n_wr;
        busy = 1; tk(4);
        bus_start; wb(dev(0), k1); wb(8'h20, k2); wb(8'h77, k3); bus_stop;
        busy = 0; tk(4);
        chk(!k1 && !k2 && !k3, "R9 no ack while busy", {k1, k2, k3}, 0);
        chk(n_wr == w0, "R9 no strobe while busy", n_wr, w0);

        // R11: START mid-byte restarts address reception
        bus_start;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start; wb(dev(0), k1); wb(8'h10, k2);
        bus_start; wb(dev(1), k3); rb(0, d); bus_stop;
        chk(k1 && k2 && k3 && d == exp_mem[8'h10], "R11 abort and restart", d, exp_mem[8'h10]);

        // R10: pull enable never moved with the clock high
        chk(n_viol == 0, "R10 pull change timing", n_viol, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule